// File: doc/BRIEF.md
# Write-Through Store Buffer

This block sits between a write-through cache and a slow memory port. The cache sends every store to it, hit or miss. Each store is a single address and data pair. The buffer keeps these pending stores in a small queue, so the processor goes on at once instead of waiting out the memory write latency, which may be a hundred cycles or more. The processor has to stall on a store only when every slot is occupied. The queue drains to memory strictly oldest first, offering one write at a time.

The cache also presents the address of each read miss to the buffer. If any pending store targets that address, a mode pin selects the response. In forwarding mode the buffer supplies the data of the newest matching store. In blocking mode it raises a wait flag until every matching store has reached memory, so a read never fetches a stale copy. A second mode pin handles store misses. In allocate mode an accepted store that missed in the cache produces a one-cycle line-fetch request. In write-around mode no fetch is requested, and the store goes to memory only.

Both data paths use valid/ready. On the store input a transfer happens on a clock edge where `st_valid` and `st_ready` are both high. `st_ready` falls whenever the queue is full, and the cache must then hold the store and its address and data stable. On the memory output `mw_valid` stays high with a stable head entry until `mw_ready` is seen high at a clock edge. Memory may hold `mw_ready` low for any number of cycles.

Top module: `wt_store_buffer`

## Requirements
- R1: A store is accepted on a rising edge where `st_valid` and `st_ready` are both high. `st_ready` is high exactly when the queue is not full.
- R2: The `full` and `empty` flags are registered. After reset `empty` is 1 and `full` is 0. `full` is 1 while DEPTH stores are pending, and `empty` is 1 while none are pending.
- R3: Stores leave on the memory port in the order they were accepted. `mw_valid` is high whenever the queue is not empty. The head address and data stay stable until a cycle in which `mw_ready` is high.
- R4: Every accepted store reaches the memory port, whether it was a cache hit or a miss (`st_miss` = 1), and in either miss mode.
- R5: When a store with `st_miss` = 1 is accepted while `alloc_mode` = 1, `fetch_valid` is high for exactly the next cycle and `fetch_addr` carries that store's address. With `alloc_mode` = 0 a missing store produces no fetch request.
- R6: With `rd_valid` high, `rd_hit` is 1 when any pending store, including the head on offer, has address `rd_addr`. In that case `rd_data` is the data of the most recently accepted matching store.
- R7: With `fwd_mode` = 0, `rd_wait` equals `rd_hit`: the read must wait. It falls once every matching store has drained. With `fwd_mode` = 1, `rd_wait` is 0.
- R8: The read check covers only stores accepted at earlier edges. A store being offered in the same cycle is not matched until the edge that accepts it has passed.
- R9: A store accepted in the same cycle that the head drains leaves the occupancy unchanged, so neither flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_mode | input | 1 | 1: request a line fetch on a store miss; 0: write-around |
| fwd_mode | input | 1 | 1: forward the newest matching data to a read; 0: make the read wait |
| st_valid | input | 1 | A store is offered |
| st_ready | output | 1 | The buffer can take a store this cycle |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| st_miss | input | 1 | The store missed in the cache |
| full | output | 1 | Registered: every slot is occupied |
| empty | output | 1 | Registered: no store is pending |
| rd_valid | input | 1 | A read miss address is presented for checking |
| rd_addr | input | AW | Read miss address |
| rd_hit | output | 1 | A pending store matches the read address |
| rd_wait | output | 1 | The read must wait for matching stores to drain |
| rd_data | output | DW | Data of the newest matching pending store |
| fetch_valid | output | 1 | One-cycle line-fetch request for an allocating store miss |
| fetch_addr | output | AW | Address of the line to fetch |
| mw_valid | output | 1 | A memory write is offered |
| mw_ready | input | 1 | Memory accepts the offered write |
| mw_addr | output | AW | Memory write address |
| mw_data | output | DW | Memory write data |

## Verification
The assertions check the handshake rules on every cycle. An offered memory write stays stable until it is taken, `mw_valid` follows the empty flag, and `full` and `empty` never hold together. They also check that an accepted store always leaves the buffer non-empty, that a fetch request always traces back to an allocating miss one cycle earlier, and that `rd_wait` occurs only as a matched read in blocking mode. Other properties depend on a sequence of stores and cannot be seen in a single cycle, so only the bench scenarios show them. These are the oldest-first order across many stores, the choice of the newest of several matching stores, the release of a waiting read after a drain, and the same-cycle exclusion. The bench also shows that a push together with a pop keeps the occupancy steady.

// File: rtl/wt_sb_pkg.sv
package wt_sb_pkg;
  // Policy on a read miss that hits a pending store.
  typedef enum logic {
    RD_BLOCK   = 1'b0,
    RD_FORWARD = 1'b1
  } rd_policy_e;

  // Occupancy change selected by the push/pop pair.
  typedef enum logic [1:0] {
    OCC_HOLD = 2'b00,
    OCC_DEC  = 2'b01,
    OCC_INC  = 2'b10,
    OCC_SWAP = 2'b11
  } occ_op_e;
endpackage

// File: rtl/wt_sb_ctrl.sv
// Pointer and occupancy control with registered full/empty flags.
module wt_sb_ctrl
  import wt_sb_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] rd_ptr,
  output logic [CW-1:0] count,
  output logic          full_q,
  output logic          empty_q
);
  localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

  occ_op_e       op;
  logic [CW-1:0] cnt_n;

  always_comb begin
    op = occ_op_e'({push, pop});
    unique case (op)
      OCC_INC: cnt_n = count + 1'b1;
      OCC_DEC: cnt_n = count - 1'b1;
      default: cnt_n = count;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      count   <= cnt_n;
      full_q  <= (cnt_n == CNT_MAX);
      empty_q <= (cnt_n == '0);
    end
  end
endmodule

// File: rtl/wt_sb_store.sv
// Entry storage, head output and newest-match read lookup.
module wt_sb_store #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = PW + 1
) (
  input  logic          clk,
  input  logic          push,
  input  logic [PW-1:0] wr_ptr,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_data,
  input  logic [PW-1:0] rd_ptr,
  input  logic [CW-1:0] count,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  input  logic [AW-1:0] look_addr,
  output logic          look_hit,
  output logic [DW-1:0] look_data
);
  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && (wr_ptr == PW'(s))) begin
        addr_q[s] <= in_addr;
        data_q[s] <= in_data;
      end
    end
  end

  assign head_addr = addr_q[rd_ptr];
  assign head_data = data_q[rd_ptr];

  // Scan from oldest to newest; the last match found is the newest.
  always_comb begin
    logic [PW-1:0] slot;
    look_hit  = 1'b0;
    look_data = '0;
    for (int k = 0; k < DEPTH; k++) begin
      slot = rd_ptr + PW'(k);
      if ((CW'(k) < count) && (addr_q[slot] == look_addr)) begin
        look_hit  = 1'b1;
        look_data = data_q[slot];
      end
    end
  end
endmodule

// File: rtl/wt_sb_fetch.sv
// Line-fetch request for store misses in allocate mode.
module wt_sb_fetch #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          miss,
  input  logic          alloc_en,
  input  logic [AW-1:0] addr,
  output logic          req_valid,
  output logic [AW-1:0] req_addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_addr  <= '0;
    end else begin
      req_valid <= accept && miss && alloc_en;
      if (accept && miss && alloc_en) req_addr <= addr;
    end
  end
endmodule

// File: rtl/wt_store_buffer.sv
module wt_store_buffer
  import wt_sb_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_mode,
  input  logic          fwd_mode,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic          st_miss,
  output logic          full,
  output logic          empty,
  input  logic          rd_valid,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_hit,
  output logic          rd_wait,
  output logic [DW-1:0] rd_data,
  output logic          fetch_valid,
  output logic [AW-1:0] fetch_addr,
  output logic          mw_valid,
  input  logic          mw_ready,
  output logic [AW-1:0] mw_addr,
  output logic [DW-1:0] mw_data
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic          push, pop;
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          full_q, empty_q;
  logic          look_hit;
  logic [DW-1:0] look_data;
  rd_policy_e    policy;

  assign st_ready = !full_q;
  assign push     = st_valid && !full_q;
  assign pop      = !empty_q && mw_ready;
  assign mw_valid = !empty_q;
  assign full     = full_q;
  assign empty    = empty_q;
  assign policy   = rd_policy_e'(fwd_mode);

  wt_sb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .count(count),
    .full_q(full_q), .empty_q(empty_q)
  );

  wt_sb_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_store (
    .clk(clk), .push(push), .wr_ptr(wr_ptr),
    .in_addr(st_addr), .in_data(st_data),
    .rd_ptr(rd_ptr), .count(count),
    .head_addr(mw_addr), .head_data(mw_data),
    .look_addr(rd_addr), .look_hit(look_hit), .look_data(look_data)
  );

  wt_sb_fetch #(.AW(AW)) u_fetch (
    .clk(clk), .rst_n(rst_n), .accept(push), .miss(st_miss),
    .alloc_en(alloc_mode), .addr(st_addr),
    .req_valid(fetch_valid), .req_addr(fetch_addr)
  );

  assign rd_hit  = rd_valid && look_hit;
  assign rd_data = look_data;
  assign rd_wait = rd_hit && (policy == RD_BLOCK);
endmodule

// File: rtl/wt_store_buffer_chk.sv
module wt_store_buffer_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          alloc_mode,
  input logic          fwd_mode,
  input logic          st_valid,
  input logic          st_ready,
  input logic          st_miss,
  input logic          full,
  input logic          empty,
  input logic          rd_hit,
  input logic          rd_wait,
  input logic          fetch_valid,
  input logic          mw_valid,
  input logic          mw_ready,
  input logic [AW-1:0] mw_addr,
  input logic [DW-1:0] mw_data
);
  assert_flags_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  assert_accept_fills_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_ready) |=> !empty);

  assert_valid_follows_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mw_valid == !empty);

  assert_head_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_valid && !mw_ready) |=> (mw_valid && $stable(mw_addr) && $stable(mw_data)));

  assert_fetch_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> $past(st_valid && st_ready && st_miss && alloc_mode));

  assert_wait_only_blocking_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_wait |-> (rd_hit && !fwd_mode));
endmodule

bind wt_store_buffer wt_store_buffer_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .alloc_mode(alloc_mode), .fwd_mode(fwd_mode),
  .st_valid(st_valid), .st_ready(st_ready), .st_miss(st_miss),
  .full(full), .empty(empty), .rd_hit(rd_hit), .rd_wait(rd_wait),
  .fetch_valid(fetch_valid), .mw_valid(mw_valid), .mw_ready(mw_ready),
  .mw_addr(mw_addr), .mw_data(mw_data)
);

// File: tb/wt_store_buffer_bench.sv
`timescale 1ns/1ps
module wt_store_buffer_bench;
  localparam int DEPTH = 4;
  localparam int AW = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_mode = 1'b0, fwd_mode = 1'b1;
  logic st_valid = 1'b0, st_miss = 1'b0;
  logic [AW-1:0] st_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic st_ready, full, empty;
  logic rd_valid = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic rd_hit, rd_wait;
  logic [DW-1:0] rd_data;
  logic fetch_valid;
  logic [AW-1:0] fetch_addr;
  logic mw_valid, mw_ready = 1'b0;
  logic [AW-1:0] mw_addr;
  logic [DW-1:0] mw_data;

  int checks = 0, errors = 0;
  logic [AW+DW-1:0] sb [$];

  always #2 clk = ~clk;

  wt_store_buffer #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_wt_store_buffer (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: offers one store, waits for acceptance, records it as expected memory traffic.
  task automatic push(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic m);
    st_valid = 1'b1; st_addr = a; st_data = d; st_miss = m;
    while (!st_ready) @(negedge clk);
    @(posedge clk);
    sb.push_back({a, d});
    #1 st_valid = 1'b0; st_miss = 1'b0;
  endtask

  // Monitor: order and content of memory writes (R3, R4).
  always @(negedge clk) begin
    if (rst_n && mw_valid && mw_ready) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL R3 actual=%0h expected=none", {mw_addr, mw_data});
      end else begin
        chk("R3 R4 drain order", 64'({mw_addr, mw_data}), 64'(sb.pop_front()));
      end
    end
  end

  task automatic drain();
    @(posedge clk); #1 mw_ready = 1'b1;
    while (!empty) @(posedge clk);
    #1 mw_ready = 1'b0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R2 reset empty", 64'(empty), 64'(1));
    chk("R2 reset full", 64'(full), 64'(0));
    chk("R3 reset mw_valid", 64'(mw_valid), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", 64'(st_ready), 64'(1));

    // Fill with memory stalled, including a repeated address.
    push(16'h0010, 32'hD1, 1'b0);
    push(16'h0020, 32'hD2, 1'b0);
    push(16'h0010, 32'hD3, 1'b0);
    push(16'h0030, 32'hD4, 1'b0);
    @(negedge clk);
    chk("R2 full at depth", 64'(full), 64'(1));
    chk("R1 ready low when full", 64'(st_ready), 64'(0));
    chk("R3 head is oldest", 64'(mw_addr), 64'(16'h0010));
    st_valid = 1'b1; st_addr = 16'h0099; st_data = 32'hEE;
    @(negedge clk);
    chk("R1 store held while full", 64'(full), 64'(1));
    st_valid = 1'b0;

    rd_valid = 1'b1; fwd_mode = 1'b1; rd_addr = 16'h0010;
    #1;
    chk("R6 hit on pending", 64'(rd_hit), 64'(1));
    chk("R6 newest data", 64'(rd_data), 64'(32'hD3));
    chk("R7 no wait when forwarding", 64'(rd_wait), 64'(0));
    rd_addr = 16'h0040; #1;
    chk("R6 no hit", 64'(rd_hit), 64'(0));
    fwd_mode = 1'b0; rd_addr = 16'h0020; #1;
    chk("R7 wait in blocking mode", 64'(rd_wait), 64'(1));

    drain();
    @(negedge clk);
    chk("R2 empty after drain", 64'(empty), 64'(1));
    chk("R7 wait released after drain", 64'(rd_wait), 64'(0));
    chk("R3 all drained", 64'(sb.size()), 64'(0));
    rd_valid = 1'b0;

    // Allocate mode on a store miss.
    alloc_mode = 1'b1;
    push(16'h0055, 32'hA5, 1'b1);
    @(negedge clk);
    chk("R5 fetch pulse", 64'(fetch_valid), 64'(1));
    chk("R5 fetch address", 64'(fetch_addr), 64'(16'h0055));
    @(negedge clk);
    chk("R5 pulse one cycle", 64'(fetch_valid), 64'(0));
    alloc_mode = 1'b0;
    push(16'h0066, 32'hB6, 1'b1);
    @(negedge clk);
    chk("R5 write-around no fetch", 64'(fetch_valid), 64'(0));
    drain();
    @(negedge clk);
    chk("R4 miss stores reached memory", 64'(sb.size()), 64'(0));

    // Same-cycle store and read check.
    fwd_mode = 1'b1;
    st_valid = 1'b1; st_addr = 16'h0077; st_data = 32'h77; rd_valid = 1'b1; rd_addr = 16'h0077;
    #1;
    chk("R8 no match before accept", 64'(rd_hit), 64'(0));
    @(posedge clk);
    sb.push_back({16'h0077, 32'h77});
    #1 st_valid = 1'b0;
    chk("R8 match after accept", 64'(rd_hit), 64'(1));
    rd_valid = 1'b0;
    push(16'h0078, 32'h78, 1'b0);

    // Push with pop each cycle: occupancy stays at two.
    @(posedge clk); #1 mw_ready = 1'b1;
    for (int i = 0; i < 6; i++) begin
      push(16'h0100 + 16'(i), 32'h100 + 32'(i), 1'b0);
      chk("R9 flags steady empty", 64'(empty), 64'(0));
      chk("R9 flags steady full", 64'(full), 64'(0));
    end

    // Random back-pressure stream.
    fork
      for (int i = 0; i < 40; i++) push(16'h0200 + 16'(i), 32'hC00 + 32'(i), 1'(i % 3 == 0));
      for (int i = 0; i < 200; i++) begin
        @(posedge clk); #1 mw_ready = 1'(($urandom % 3) != 0);
      end
    join
    drain();
    @(negedge clk);
    chk("R3 stream fully drained", 64'(sb.size()), 64'(0));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule